// File: doc/BRIEF.md
# Cascadable Unsigned Magnitude Comparator

This block compares two unsigned words and raises exactly one of three flags: the first operand is greater, the two are equal, or the first operand is less. It is built from identical 4-bit slices. Each slice forms its own local verdict from bitwise equivalence terms and sum-of-products greater and less equations. It then merges that verdict with the verdict passed up from the slice below. A slice's local decision wins whenever its own nibbles differ. When they match, it passes on the verdict from below.

The top module chains a parameterised number of slices, from least to most significant, so one design serves 4, 8, 12 or more bits. The least significant slice is seeded with an "equal" verdict. The block is purely combinational: it has no clock and no state, and the flags follow the operands within the same cycle.

Top module: `mag_cmp_chain`

## Requirements
- R1: `eq_o` is 1 exactly when `a_i` equals `b_i` on every bit.
- R2: `gt_o` is 1 exactly when `a_i` is greater than `b_i`, both read as unsigned binary numbers.
- R3: `lt_o` is 1 exactly when `a_i` is less than `b_i`, both read as unsigned binary numbers.
- R4: For any operands without unknown bits, exactly one of `gt_o`, `eq_o` and `lt_o` is 1.
- R5: When the most significant 4-bit slices of `a_i` and `b_i` differ, the flags depend only on those two slices. Every lower slice has no effect on the flags.
- R6: When the upper slices match, the flags equal the comparison of the lower slices.
- R7: The lowest slice is seeded with equal=1, greater=0 and less=0. Identical operands, including all zeros and all ones, therefore give `eq_o`=1, `gt_o`=0 and `lt_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | STAGES*4 | First unsigned operand |
| b_i | input | STAGES*4 | Second unsigned operand |
| gt_o | output | 1 | a_i is greater than b_i |
| eq_o | output | 1 | a_i equals b_i |
| lt_o | output | 1 | a_i is less than b_i |

## Verification
The bench builds the chain with STAGES=2, which gives an 8-bit comparator. At that size every pair of operands can be swept, 65536 in all. The sweep exercises each slice's local equations and the merge path, both where the upper slice decides and where it defers to the lower one. Expected flags come from integer comparison of the operands and of their separate nibbles. The bench also checks the all-zero and all-one boundaries.

// File: rtl/mag_cmp_pkg.sv
package mag_cmp_pkg;

    typedef struct packed {
        logic gt;
        logic eq;
        logic lt;
    } cmp_flags_t;

    localparam cmp_flags_t SEED_EQUAL = '{gt: 1'b0, eq: 1'b1, lt: 1'b0};

endpackage

// File: rtl/mag_slice_local.sv
module mag_slice_local
    import mag_cmp_pkg::*;
#(
    parameter int SLICE_W = 4
) (
    input  logic [SLICE_W-1:0] a_i,
    input  logic [SLICE_W-1:0] b_i,
    output cmp_flags_t         local_o
);

    logic [SLICE_W-1:0] same_d;

    // bitwise equivalence terms
    generate
        for (genvar i = 0; i < SLICE_W; i++) begin : g_same
            assign same_d[i] = ~(a_i[i] ^ b_i[i]);
        end
    endgenerate

    cmp_flags_t res_d;

    // sum of products: each term needs all higher bits equal
    always_comb begin
        logic upper_same;
        upper_same = 1'b1;
        res_d      = '0;
        for (int i = SLICE_W - 1; i >= 0; i--) begin
            res_d.gt   = res_d.gt | (upper_same & a_i[i] & ~b_i[i]);
            res_d.lt   = res_d.lt | (upper_same & ~a_i[i] & b_i[i]);
            upper_same = upper_same & same_d[i];
        end
        res_d.eq = upper_same;
    end

    assign local_o = res_d;

endmodule

// File: rtl/mag_slice_merge.sv
module mag_slice_merge
    import mag_cmp_pkg::*;
(
    input  cmp_flags_t local_i,
    input  cmp_flags_t below_i,
    output cmp_flags_t merged_o
);

    cmp_flags_t merged_d;

    always_comb begin
        merged_d.gt = local_i.gt | (local_i.eq & below_i.gt);
        merged_d.eq = local_i.eq & below_i.eq;
        merged_d.lt = local_i.lt | (local_i.eq & below_i.lt);
    end

    assign merged_o = merged_d;

endmodule

// File: rtl/mag_slice.sv
module mag_slice
    import mag_cmp_pkg::*;
#(
    parameter int SLICE_W = 4
) (
    input  logic [SLICE_W-1:0] a_i,
    input  logic [SLICE_W-1:0] b_i,
    input  cmp_flags_t         below_i,
    output cmp_flags_t         out_o
);

    cmp_flags_t local_d;

    mag_slice_local #(.SLICE_W(SLICE_W)) u_local (
        .a_i     (a_i),
        .b_i     (b_i),
        .local_o (local_d)
    );

    mag_slice_merge u_merge (
        .local_i  (local_d),
        .below_i  (below_i),
        .merged_o (out_o)
    );

endmodule

// File: rtl/mag_cmp_chain.sv
module mag_cmp_chain
    import mag_cmp_pkg::*;
#(
    parameter int STAGES  = 3,
    parameter int SLICE_W = 4
) (
    input  logic [STAGES*SLICE_W-1:0] a_i,
    input  logic [STAGES*SLICE_W-1:0] b_i,
    output logic                      gt_o,
    output logic                      eq_o,
    output logic                      lt_o
);

    localparam int W = STAGES * SLICE_W;

    cmp_flags_t chain_d [STAGES+1];

    // lowest slice sees an "equal" verdict from below (R7)
    assign chain_d[0] = SEED_EQUAL;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_slice
            mag_slice #(.SLICE_W(SLICE_W)) u_slice (
                .a_i     (a_i[s*SLICE_W +: SLICE_W]),
                .b_i     (b_i[s*SLICE_W +: SLICE_W]),
                .below_i (chain_d[s]),
                .out_o   (chain_d[s+1])
            );
        end
    endgenerate

    assign gt_o = chain_d[STAGES].gt;
    assign eq_o = chain_d[STAGES].eq;
    assign lt_o = chain_d[STAGES].lt;

endmodule

// File: rtl/mag_cmp_chain_chk.sv
module mag_cmp_chain_chk #(
    parameter int STAGES  = 3,
    parameter int SLICE_W = 4
) (
    input logic [STAGES*SLICE_W-1:0] a_i,
    input logic [STAGES*SLICE_W-1:0] b_i,
    input logic                      gt_o,
    input logic                      eq_o,
    input logic                      lt_o
);

    localparam int W = STAGES * SLICE_W;

    always_comb begin
        if (!$isunknown({a_i, b_i})) begin
            AST_EQ_MATCH: assert (eq_o == (a_i == b_i)) else $error("eq flag mismatch"); // R1
            AST_GT_MATCH: assert (gt_o == (a_i > b_i)) else $error("gt flag mismatch"); // R2
            AST_LT_MATCH: assert (lt_o == (a_i < b_i)) else $error("lt flag mismatch"); // R3
            AST_ONE_FLAG: assert ($countones({gt_o, eq_o, lt_o}) == 1) else $error("flags not one-hot"); // R4
            if (a_i[W-1 -: SLICE_W] != b_i[W-1 -: SLICE_W]) begin
                AST_TOP_DECIDES: assert (gt_o == (a_i[W-1 -: SLICE_W] > b_i[W-1 -: SLICE_W])) else $error("top slice not deciding"); // R5
            end
        end
    end

endmodule

bind mag_cmp_chain mag_cmp_chain_chk #(.STAGES(STAGES), .SLICE_W(SLICE_W)) u_chk (
    .a_i  (a_i),
    .b_i  (b_i),
    .gt_o (gt_o),
    .eq_o (eq_o),
    .lt_o (lt_o)
);

// File: tb/tb_mag_cmp_chain.sv
`timescale 1ns/1ps
module tb_mag_cmp_chain;

    localparam int STAGES = 2;
    localparam int W      = STAGES * 4;

    logic         clk = 1'b0;
    logic [W-1:0] a, b;
    logic         gt, eq, lt;
    int           checks = 0;
    int           errors = 0;
    bit           done   = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    mag_cmp_chain #(.STAGES(STAGES)) dut (
        .a_i  (a),
        .b_i  (b),
        .gt_o (gt),
        .eq_o (eq),
        .lt_o (lt)
    );

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s a=%0d b=%0d flags(gt,eq,lt) actual=%b expected=%b", req, a, b, act, exp);
        end
    endtask

    function automatic logic [2:0] cmp3(input int x, input int y);
        return {x > y, x == y, x < y};
    endfunction

    task automatic apply(input int x, input int y);
        @(posedge clk);
        a = x[W-1:0];
        b = y[W-1:0];
        @(negedge clk);
    endtask

    initial begin
        a = '0;
        b = '0;
        // R7: first state, identical zero operands
        @(negedge clk);
        check("R7", {gt, eq, lt}, 3'b010);

        // full sweep of the 8-bit configuration
        for (int x = 0; x < (1 << W); x++) begin
            for (int y = 0; y < (1 << W); y++) begin
                int xh, yh, xl, yl;
                apply(x, y);
                xh = x >> 4; yh = y >> 4;
                xl = x & 15; yl = y & 15;
                check("R1", {1'b0, eq, 1'b0}, {1'b0, x == y, 1'b0});
                check("R2", {gt, 2'b00}, {x > y, 2'b00});
                check("R3", {2'b00, lt}, {2'b00, x < y});
                check("R4", {2'b00, ({gt, eq, lt} == 3'b100) || ({gt, eq, lt} == 3'b010) || ({gt, eq, lt} == 3'b001)}, 3'b001);
                if (xh != yh)
                    check("R5", {gt, eq, lt}, cmp3(xh, yh));
                else
                    check("R6", {gt, eq, lt}, cmp3(xl, yl));
            end
        end

        // R7: all-one boundary, and extremes in both orders
        apply((1 << W) - 1, (1 << W) - 1);
        check("R7", {gt, eq, lt}, 3'b010);
        apply((1 << W) - 1, 0);
        check("R2", {gt, eq, lt}, 3'b100);
        apply(0, (1 << W) - 1);
        check("R3", {gt, eq, lt}, 3'b001);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule